// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block is a small storage array for a processor datapath. It holds a set of data words, four words of 32 bits by default. Two read ports run side by side, and each one gives back the word picked by its own register number. One write port stores a data word into the register picked by its write number, at the rising clock edge, while its write strobe is high.

Reads are purely combinational, through one selector per port. Writes use a one-hot decoder. The decoder output, ANDed with the write strobe, acts as a clock enable on a single free-running clock, so no clock is gated in logic. An active-low reset clears every word at once, without waiting for a clock edge.

A parameter picks how the read selectors are built: an indexed multiplexer, or an AND-OR tree. Elaboration-time checks reject a word count that is not a power of two, and any width below its minimum.

Top module: `regfile_2r1w`

## Requirements
- R1: While `rst_n` is 0, every register reads as zero on both ports. The clearing takes effect asynchronously, between clock edges.
- R2: At a rising edge of `clk` with `wr_en` = 1 and `rst_n` = 1, the register numbered `wr_addr` takes the value on `wr_data`.
- R3: A write changes only the addressed register. At most one register is enabled for update at any edge.
- R4: At a rising edge with `wr_en` = 0, no register changes, whatever `wr_addr` and `wr_data` hold.
- R5: `rd_data_a` always shows the current contents of the register numbered `rd_addr_a`. It follows an address change with no clock edge needed.
- R6: `rd_data_b` shows the register numbered `rd_addr_b` independently of port A. When both ports name the same register, both give the same value.
- R7: A read of the register being written returns the old contents until the rising edge that stores the write. After that edge it returns the new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock; writes occur on its rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of all registers |
| rd_addr_a | input | ADDR_W (2) | Register number for read port A |
| rd_data_a | output | DATA_W (32) | Contents of the register chosen by `rd_addr_a` |
| rd_addr_b | input | ADDR_W (2) | Register number for read port B |
| rd_data_b | output | DATA_W (32) | Contents of the register chosen by `rd_addr_b` |
| wr_en | input | 1 | Write strobe; qualifies the update at the rising edge |
| wr_addr | input | ADDR_W (2) | Register number to be written |
| wr_data | input | DATA_W (32) | Word to store |

## Verification
Two activities can fall in the same cycle here: a write into a register, and a read of that same register on one or both ports. The bench provokes this overlap by pointing both read ports at the write target while the strobe is high. It samples the ports after the inputs settle but before the edge, and again just after the edge. It expects the old word first and the new word second. The bench also drops the reset in the middle of a clock period and expects zeros on every read address before the next edge arrives.

// File: rtl/rf_pkg.sv
package rf_pkg;

   // Implementation choice for the read selectors.
   typedef enum logic [0:0] {
      RSEL_INDEX = 1'b0,   // indexed multiplexer
      RSEL_ANDOR = 1'b1    // decoded AND-OR reduction
   } rsel_style_e;

endpackage

// File: rtl/rf_wdec.sv
// One-hot write-select decoder, qualified by the global write strobe.
module rf_wdec #(
   parameter int NUM_REGS = 4,
   localparam int ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic                en_i,
   input  logic [ADDR_W-1:0]   addr_i,
   output logic [NUM_REGS-1:0] sel_o
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
      assign sel_o[i] = en_i && (addr_i == ADDR_W'(i));
   end

   // R3: never more than one register enabled
   always_comb begin
      a_r3_single_sel: assert ($onehot0(sel_o))
         else $error("write decoder enabled more than one register");
   end

endmodule

// File: rtl/rf_word.sv
// One storage word: asynchronous active-low clear, synchronous clock enable.
module rf_word #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o <= '0;
      end else if (ld_i) begin
         q_o <= d_i;
      end
   end

   // R1: held at zero during reset
   a_r1_cleared: assert property (@(posedge clk) !rst_n |-> q_o == '0)
      else $error("word not cleared under reset");

   // R2: loaded word appears after the enabled edge
   a_r2_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      ld_i |=> q_o == $past(d_i))
      else $error("word did not capture write data");

   // R4: unselected word keeps its value
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_i |=> $stable(q_o))
      else $error("word changed without enable");

endmodule

// File: rtl/rf_rsel.sv
// Read selector; the construction is chosen by parameter.
module rf_rsel #(
   parameter int                  DATA_W   = 32,
   parameter int                  NUM_REGS = 4,
   parameter rf_pkg::rsel_style_e STYLE    = rf_pkg::RSEL_INDEX,
   localparam int                 ADDR_W   = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0] words_i,
   input  logic [ADDR_W-1:0]               addr_i,
   output logic [DATA_W-1:0]               data_o
);

   if (STYLE == rf_pkg::RSEL_INDEX) begin : g_index
      assign data_o = words_i[addr_i];
   end else begin : g_andor
      always_comb begin
         data_o = '0;
         for (int i = 0; i < NUM_REGS; i++) begin
            data_o = data_o | (words_i[i] & {DATA_W{addr_i == ADDR_W'(i)}});
         end
      end
   end

endmodule

// File: rtl/regfile_2r1w.sv
// Register file with two combinational read ports and one write port.
module regfile_2r1w #(
   parameter int                  DATA_W     = 32,
   parameter int                  NUM_REGS   = 4,
   parameter rf_pkg::rsel_style_e RSEL_STYLE = rf_pkg::RSEL_INDEX,
   localparam int                 ADDR_W     = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr_a,
   output logic [DATA_W-1:0] rd_data_a,
   input  logic [ADDR_W-1:0] rd_addr_b,
   output logic [DATA_W-1:0] rd_data_b,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data
);

   // elaboration-time parameter checks
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end
   if (NUM_REGS < 2) begin : g_bad_depth
      $error("NUM_REGS must be at least 2");
   end
   if ((1 << ADDR_W) != NUM_REGS) begin : g_bad_pow2
      $error("NUM_REGS must be a power of two");
   end

   logic [NUM_REGS-1:0]             wr_sel;
   logic [NUM_REGS-1:0][DATA_W-1:0] word_q;

   rf_wdec #(.NUM_REGS(NUM_REGS)) u_wdec (
      .en_i   (wr_en),
      .addr_i (wr_addr),
      .sel_o  (wr_sel)
   );

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      rf_word #(.DATA_W(DATA_W)) u_word (
         .clk   (clk),
         .rst_n (rst_n),
         .ld_i  (wr_sel[i]),
         .d_i   (wr_data),
         .q_o   (word_q[i])
      );
   end

   rf_rsel #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .STYLE(RSEL_STYLE)) u_rsel_a (
      .words_i (word_q),
      .addr_i  (rd_addr_a),
      .data_o  (rd_data_a)
   );

   rf_rsel #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .STYLE(RSEL_STYLE)) u_rsel_b (
      .words_i (word_q),
      .addr_i  (rd_addr_b),
      .data_o  (rd_data_b)
   );

   // R6: two ports on one register agree
   a_r6_ports_agree: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr_a == rd_addr_b) |-> (rd_data_a == rd_data_b))
      else $error("read ports disagree on the same register");

endmodule

// File: tb/regfile_2r1w_bench.sv
module regfile_2r1w_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [1:0]  rd_addr_a, rd_addr_b, wr_addr;
   logic        wr_en;
   logic [31:0] wr_data;
   logic [31:0] rd_data_a, rd_data_b, ao_data_a, ao_data_b;

   logic [31:0] model [4];
   int          n_checks = 0;
   int          n_fail   = 0;

   always #4 clk = ~clk;   // 125 MHz

   regfile_2r1w u_regfile_2r1w (
      .clk(clk), .rst_n(rst_n),
      .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
      .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   regfile_2r1w #(.RSEL_STYLE(rf_pkg::RSEL_ANDOR)) u_regfile_2r1w_andor (
      .clk(clk), .rst_n(rst_n),
      .rd_addr_a(rd_addr_a), .rd_data_a(ao_data_a),
      .rd_addr_b(rd_addr_b), .rd_data_b(ao_data_b),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // every address pair on both ports, both selector styles
   task automatic sweep(input string req_a, input string req_b);
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            rd_addr_a = 2'(a);
            rd_addr_b = 2'(b);
            #1;
            chk(req_a, rd_data_a, model[a]);
            chk(req_b, rd_data_b, model[b]);
            chk(req_a, ao_data_a, model[a]);
            chk(req_b, ao_data_b, model[b]);
         end
      end
   endtask

   task automatic do_write(input logic en, input logic [1:0] addr, input logic [31:0] data);
      @(negedge clk);
      wr_en   = en;
      wr_addr = addr;
      wr_data = data;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      if (en) model[addr] = data;
   endtask

   function automatic logic [31:0] pattern(input int round, input int idx);
      return (32'h9E3779B9 * (round * 4 + idx + 1)) ^ (32'h01010101 << idx);
   endfunction

   initial begin : watchdog
      #100000;
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      rst_n = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      rd_addr_a = '0; rd_addr_b = '0;
      for (int i = 0; i < 4; i++) model[i] = '0;
      #2 rst_n = 1'b0;
      #1;
      sweep("R1", "R1");                     // cleared under reset
      @(negedge clk);
      rst_n = 1'b1;

      for (int r = 0; r < 3; r++) begin
         for (int i = 0; i < 4; i++) begin
            do_write(1'b1, 2'(i), pattern(r, i));
            sweep("R2/R3", "R2/R3");         // target written, others unchanged
         end
         sweep("R5", "R6");                  // all pairs, incl. same register
         for (int i = 0; i < 4; i++) begin
            do_write(1'b0, 2'(i), ~pattern(r, i));
            sweep("R4", "R4");               // strobe low: nothing changes
         end
      end

      // R7: read of the register under write, before and after the edge
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         rd_addr_a = 2'(i);
         rd_addr_b = 2'(i);
         wr_en     = 1'b1;
         wr_addr   = 2'(i);
         wr_data   = 32'hC0DE0000 | 32'(i);
         #1;
         chk("R7", rd_data_a, model[i]);
         chk("R7", rd_data_b, model[i]);
         @(posedge clk);
         #1;
         wr_en = 1'b0;
         model[i] = 32'hC0DE0000 | 32'(i);
         chk("R7", rd_data_a, model[i]);
         chk("R7", rd_data_b, model[i]);
         chk("R7", ao_data_a, model[i]);
      end

      // R1: reset asserted mid-period clears at once
      @(negedge clk);
      #1 rst_n = 1'b0;
      for (int i = 0; i < 4; i++) model[i] = '0;
      #1;
      rd_addr_a = 2'd3;
      rd_addr_b = 2'd1;
      #0.5;
      chk("R1", rd_data_a, 32'h0);
      chk("R1", rd_data_b, 32'h0);
      sweep("R1", "R1");
      @(negedge clk);
      rst_n = 1'b1;
      do_write(1'b1, 2'd2, 32'h12345678);
      sweep("R2", "R2");

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule